// File: doc/BRIEF.md
# Burst-Access UART FIFO Host Port

This block is the host-facing side of a 16550-style serial port's data path. A host reaches it through a 32-bit memory-mapped access port and can move receive or transmit data one byte or one 32-bit word at a time. In a word transfer, byte lane 0 (bits [7:0]) carries the oldest byte of the stream and lane 3 the newest. A single packed status word reports the receive fill level, the transmit free space, an interrupt-idle indication and the line-status error flags. A driver can therefore plan a whole service pass from one read: word transfers move the bulk of the data and single-byte transfers move the remainder.

The receive FIFO is filled one byte per cycle by a line-side source. That source also supplies parity and framing error marks with each byte. The transmit FIFO is drained one byte per cycle by a line-side sink through a valid/ready pair. The serial shifter, the baud generator and the interrupt controller lie outside this block. The interrupt controller shows up only as a single pending input. Both FIFOs hold `DEPTH` bytes, where `DEPTH` is a power of two of at most 128. Read data is registered.

Top module: `bfp_burst_port`

## Requirements
- R1: After reset, both FIFOs are empty, all sticky flags are clear and `bus_rdata` is zero. A status read with `irq_pending` low returns 0x2010_1000 when `DEPTH` is 16.
- R2: A word write at offset 0xA0 appends up to four bytes to the transmit FIFO, lane 0 first. The sink then receives the bytes in stream order.
- R3: A word read at offset 0xA4 returns up to four receive bytes, the oldest in lane 0, and removes only the bytes it returns. Lanes with no byte behind them read as zero.
- R4: Byte accesses at offset 0x00 behave as follows. A byte write appends `bus_wdata[7:0]` to the transmit FIFO. A byte read removes the oldest receive byte and returns it in bits [7:0], or returns zero when the receive FIFO is empty.
- R5: Bytes of a transmit write that find no free slot are discarded, and the sticky transmit-overflow flag, status bit 16, is set. Only a control write of 0x43 clears it.
- R6: A byte that arrives from the line while the receive FIFO is full is discarded, and the sticky overrun flag, status bit 25, is set. A byte write of 0x43 to the control offset 0x02 clears it, and any other control value leaves it set.
- R7: A byte arriving with a parity mark sets status bit 26, and one arriving with a framing mark sets bit 27. Bit 31 is the OR of these two. Both flags stay set until the next status read, and that read clears them after reporting them.
- R8: Status bit 20 is 1 when `irq_pending` is low and 0 when it is high.
- R9: Read data appears on `bus_rdata` in the cycle after the read access. It holds that value until the next read access.
- R10: The status word is a word read at offset 0x9C with the following fields:
  - [7:0]: receive fill count.
  - [15:8]: transmit free count.
  - Bit 24: receive data ready (fill count nonzero).
  - Bit 29: transmit FIFO empty.
  - All other bits not named in R5 to R8 read as zero.
- R11: Accesses whose offset or width matches none of the windows above change no state, and reads of them return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Host access strobe, one access per cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = 32-bit access, 0 = byte access |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data; byte accesses use bits [7:0] |
| bus_rdata | output | 32 | Registered read data |
| rx_in_valid | input | 1 | Line source delivers a received byte |
| rx_in_byte | input | 8 | Received byte |
| rx_in_perr | input | 1 | Parity error mark for this byte |
| rx_in_ferr | input | 1 | Framing error mark for this byte |
| irq_pending | input | 1 | Interrupt controller has a pending cause |
| tx_out_valid | output | 1 | Transmit FIFO holds a byte for the sink |
| tx_out_byte | output | 8 | Oldest transmit byte |
| tx_out_ready | input | 1 | Sink takes the byte at this edge |

## Verification
Every bus read lands in `bus_rdata` at the clock edge that samples the access. The bench drives each access at a falling edge and compares the result at the following falling edge, one cycle later. Writes, line-side arrivals and sticky-flag changes are visible in the status word read in the next access cycle, and the bench's reference model is advanced exactly once per access. The transmit sink output is combinational from the FIFO head, so with ready held high the bench expects one new byte at each falling edge and compares it before the edge that consumes it.

// File: rtl/bfp_pkg.sv
package bfp_pkg;

  localparam int LANES   = 4;
  localparam int LANE_CW = $clog2(LANES + 1);

  localparam logic [11:0] OFS_DATA  = 12'h000;
  localparam logic [11:0] OFS_FCTL  = 12'h002;
  localparam logic [11:0] OFS_STAT  = 12'h09C;
  localparam logic [11:0] OFS_TXWIN = 12'h0A0;
  localparam logic [11:0] OFS_RXWIN = 12'h0A4;

  localparam logic [7:0] FCTL_CLEAR = 8'h43;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_BYTE_PUSH,
    OP_BYTE_POP,
    OP_FCTL,
    OP_STAT,
    OP_WORD_PUSH,
    OP_WORD_POP
  } host_op_e;

  typedef struct packed {
    logic rx_err_any;
    logic thr_empty;
    logic framing;
    logic parity;
    logic overrun;
    logic data_ready;
    logic no_irq;
    logic tx_ovf;
  } stat_bits_t;

  // Number of lanes a transfer may move: the smaller of demand and room.
  function automatic logic [LANE_CW-1:0] lanes_granted(input int unsigned avail,
                                                       input int unsigned want);
    return LANE_CW'((avail < want) ? avail : want);
  endfunction

  // Packs the status word from counts and flag bits.
  function automatic logic [31:0] pack_status(input logic [7:0] rx_count,
                                              input logic [7:0] tx_free,
                                              input stat_bits_t s);
    return {s.rx_err_any, 1'b0, s.thr_empty, 1'b0,
            s.framing, s.parity, s.overrun, s.data_ready,
            3'b000, s.no_irq, 3'b000, s.tx_ovf,
            tx_free, rx_count};
  endfunction

endpackage

// File: rtl/bfp_byte_fifo.sv
module bfp_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int LANES = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int NW = $clog2(LANES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NW-1:0]      push_n,
  input  logic [LANES*8-1:0] push_data,
  input  logic [NW-1:0]      pop_n,
  output logic [LANES*8-1:0] peek_data,
  output logic [CW-1:0]      level,
  output logic [CW-1:0]      space
);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic [CW-1:0] level_q;

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (NW'(l) < push_n) begin
        mem[wr_ptr + AW'(l)] <= push_data[l*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      level_q <= '0;
    end else begin
      wr_ptr  <= wr_ptr + AW'(push_n);
      rd_ptr  <= rd_ptr + AW'(pop_n);
      level_q <= level_q + CW'(push_n) - CW'(pop_n);
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_peek
    assign peek_data[g*8 +: 8] = mem[rd_ptr + AW'(g)];
  end

  assign level = level_q;
  assign space = CW'(DEPTH) - level_q;

  AST_PUSH_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    32'(push_n) <= 32'(space)); // R5
  AST_POP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    32'(pop_n) <= 32'(level)); // R3
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(level) <= DEPTH); // R1

endmodule

// File: rtl/bfp_host_decode.sv
module bfp_host_decode
  import bfp_pkg::*;
(
  input  logic        bus_valid,
  input  logic        bus_write,
  input  logic        bus_word,
  input  logic [11:0] bus_addr,
  output host_op_e    op
);

  always_comb begin
    op = OP_NONE;
    if (bus_valid) begin
      if (!bus_word && bus_addr == OFS_DATA) begin
        op = bus_write ? OP_BYTE_PUSH : OP_BYTE_POP;
      end else if (!bus_word && bus_write && bus_addr == OFS_FCTL) begin
        op = OP_FCTL;
      end else if (bus_word && !bus_write && bus_addr == OFS_STAT) begin
        op = OP_STAT;
      end else if (bus_word && bus_write && bus_addr == OFS_TXWIN) begin
        op = OP_WORD_PUSH;
      end else if (bus_word && !bus_write && bus_addr == OFS_RXWIN) begin
        op = OP_WORD_POP;
      end
    end
  end

endmodule

// File: rtl/bfp_line_flags.sv
module bfp_line_flags
  import bfp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_drop,
  input  logic       perr_hit,
  input  logic       ferr_hit,
  input  logic       tx_ovf_hit,
  input  logic       stat_read,
  input  logic       ctl_write,
  input  logic [7:0] ctl_byte,
  output logic       overrun,
  output logic       parity,
  output logic       framing,
  output logic       tx_ovf
);

  logic ctl_clear;
  assign ctl_clear = ctl_write && (ctl_byte == FCTL_CLEAR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      overrun <= 1'b0;
      parity  <= 1'b0;
      framing <= 1'b0;
      tx_ovf  <= 1'b0;
    end else begin
      if (rx_drop)         overrun <= 1'b1;
      else if (ctl_clear)  overrun <= 1'b0;
      if (tx_ovf_hit)      tx_ovf  <= 1'b1;
      else if (ctl_clear)  tx_ovf  <= 1'b0;
      if (perr_hit)        parity  <= 1'b1;
      else if (stat_read)  parity  <= 1'b0;
      if (ferr_hit)        framing <= 1'b1;
      else if (stat_read)  framing <= 1'b0;
    end
  end

  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop |=> overrun); // R6
  AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ctl_clear) |=> overrun); // R6
  AST_TXOVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ovf_hit |=> tx_ovf); // R5
  AST_PERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_read && !perr_hit) |=> !parity); // R7

endmodule

// File: rtl/bfp_burst_port.sv
module bfp_burst_port
  import bfp_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_valid,
  input  logic        bus_write,
  input  logic        bus_word,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        rx_in_valid,
  input  logic [7:0]  rx_in_byte,
  input  logic        rx_in_perr,
  input  logic        rx_in_ferr,
  input  logic        irq_pending,
  output logic        tx_out_valid,
  output logic [7:0]  tx_out_byte,
  input  logic        tx_out_ready
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam int DW = LANES * 8;

  host_op_e           op;
  logic [CW-1:0]      rx_level, rx_space, tx_level, tx_space;
  logic [LANE_CW-1:0] rx_push_n, rx_pop_n, tx_push_n, tx_pop_n;
  logic [DW-1:0]      rx_peek, tx_peek, rx_push_data, pop_lanes;
  logic               rx_full, rx_drop, tx_ovf_hit, rd_fire, stat_read;
  logic               ovr_q, par_q, frm_q, txovf_q;
  stat_bits_t         sbits;
  logic [31:0]        status_word, rdata_d;

  bfp_host_decode i_decode (
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_word  (bus_word),
    .bus_addr  (bus_addr),
    .op        (op)
  );

  // Receive side: line source pushes, host pops.
  assign rx_full      = (rx_level == CW'(DEPTH));
  assign rx_drop      = rx_in_valid && rx_full;
  assign rx_push_n    = (rx_in_valid && !rx_full) ? LANE_CW'(1) : '0;
  assign rx_push_data = {{(DW-8){1'b0}}, rx_in_byte};

  always_comb begin
    case (op)
      OP_WORD_POP: rx_pop_n = lanes_granted(32'(rx_level), LANES);
      OP_BYTE_POP: rx_pop_n = lanes_granted(32'(rx_level), 1);
      default:     rx_pop_n = '0;
    endcase
  end

  bfp_byte_fifo #(.DEPTH(DEPTH), .LANES(LANES)) i_rx_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_n    (rx_push_n),
    .push_data (rx_push_data),
    .pop_n     (rx_pop_n),
    .peek_data (rx_peek),
    .level     (rx_level),
    .space     (rx_space)
  );

  // Transmit side: host pushes, line sink pops.
  always_comb begin
    case (op)
      OP_WORD_PUSH: tx_push_n = lanes_granted(32'(tx_space), LANES);
      OP_BYTE_PUSH: tx_push_n = lanes_granted(32'(tx_space), 1);
      default:      tx_push_n = '0;
    endcase
  end

  assign tx_ovf_hit = ((op == OP_WORD_PUSH) && (32'(tx_space) < LANES)) ||
                      ((op == OP_BYTE_PUSH) && (tx_space == '0));
  assign tx_out_valid = (tx_level != '0);
  assign tx_out_byte  = tx_peek[7:0];
  assign tx_pop_n     = (tx_out_valid && tx_out_ready) ? LANE_CW'(1) : '0;

  bfp_byte_fifo #(.DEPTH(DEPTH), .LANES(LANES)) i_tx_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_n    (tx_push_n),
    .push_data (bus_wdata),
    .pop_n     (tx_pop_n),
    .peek_data (tx_peek),
    .level     (tx_level),
    .space     (tx_space)
  );

  // Sticky line-status and overflow flags.
  assign stat_read = (op == OP_STAT);

  bfp_line_flags i_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_drop    (rx_drop),
    .perr_hit   (rx_in_valid && rx_in_perr),
    .ferr_hit   (rx_in_valid && rx_in_ferr),
    .tx_ovf_hit (tx_ovf_hit),
    .stat_read  (stat_read),
    .ctl_write  (op == OP_FCTL),
    .ctl_byte   (bus_wdata[7:0]),
    .overrun    (ovr_q),
    .parity     (par_q),
    .framing    (frm_q),
    .tx_ovf     (txovf_q)
  );

  always_comb begin
    sbits            = '0;
    sbits.rx_err_any = par_q || frm_q;
    sbits.thr_empty  = (tx_level == '0);
    sbits.framing    = frm_q;
    sbits.parity     = par_q;
    sbits.overrun    = ovr_q;
    sbits.data_ready = (rx_level != '0);
    sbits.no_irq     = !irq_pending;
    sbits.tx_ovf     = txovf_q;
  end

  assign status_word = pack_status(8'(rx_level), 8'(tx_space), sbits);

  // Lanes beyond the granted pop count read as zero.
  for (genvar g = 0; g < LANES; g++) begin : g_lane_mask
    assign pop_lanes[g*8 +: 8] = (LANE_CW'(g) < rx_pop_n) ? rx_peek[g*8 +: 8] : 8'h00;
  end

  assign rd_fire = bus_valid && !bus_write;

  always_comb begin
    case (op)
      OP_WORD_POP, OP_BYTE_POP: rdata_d = pop_lanes;
      OP_STAT:                  rdata_d = status_word;
      default:                  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bus_rdata <= '0;
    else if (rd_fire) bus_rdata <= rdata_d;
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> $stable(bus_rdata)); // R9
  AST_RX_DROP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop |=> (rx_level == CW'(DEPTH)) || $past(rx_pop_n != '0)); // R6
  AST_STATUS_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_read |=> (bus_rdata[30] == 1'b0 && bus_rdata[28] == 1'b0))); // R10

endmodule

// File: tb/test_bfp_burst_port.sv
module test_bfp_burst_port;

  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0, bus_word = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_in_valid = 1'b0, rx_in_perr = 1'b0, rx_in_ferr = 1'b0;
  logic [7:0]  rx_in_byte = '0;
  logic        irq_pending = 1'b0;
  logic        tx_out_valid;
  logic [7:0]  tx_out_byte;
  logic        tx_out_ready = 1'b0;

  always #5 clk = ~clk;

  bfp_burst_port #(.DEPTH(DEPTH)) i_bfp_burst_port (
    .clk (clk), .rst_n (rst_n),
    .bus_valid (bus_valid), .bus_write (bus_write), .bus_word (bus_word),
    .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .rx_in_valid (rx_in_valid), .rx_in_byte (rx_in_byte),
    .rx_in_perr (rx_in_perr), .rx_in_ferr (rx_in_ferr),
    .irq_pending (irq_pending),
    .tx_out_valid (tx_out_valid), .tx_out_byte (tx_out_byte),
    .tx_out_ready (tx_out_ready)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  // Reference model
  byte unsigned rxq[$];
  byte unsigned txq[$];
  bit m_ovr = 0, m_txovf = 0, m_pe = 0, m_fe = 0;

  function automatic logic [31:0] exp_status(input bit irq);
    logic [31:0] s;
    s        = '0;
    s[7:0]   = 8'(rxq.size());
    s[15:8]  = 8'(DEPTH - txq.size());
    s[16]    = m_txovf;
    s[20]    = !irq;
    s[24]    = (rxq.size() != 0);
    s[25]    = m_ovr;
    s[26]    = m_pe;
    s[27]    = m_fe;
    s[29]    = (txq.size() == 0);
    s[31]    = m_pe | m_fe;
    return s;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_bus(input bit wr, input bit word, input logic [11:0] addr,
                        input logic [31:0] wdata);
    bus_valid = 1'b1; bus_write = wr; bus_word = word;
    bus_addr = addr; bus_wdata = wdata;
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; bus_word = 1'b0;
  endtask

  task automatic t_status(input bit irq, input string tag);
    logic [31:0] e;
    irq_pending = irq;
    e = exp_status(irq);
    do_bus(0, 1, 12'h09C, '0);
    check(tag, bus_rdata, e);
    m_pe = 0; m_fe = 0;
  endtask

  task automatic t_word_push(input logic [31:0] d);
    int room;
    room = DEPTH - txq.size();
    for (int l = 0; l < 4; l++) begin
      if (l < room) txq.push_back(d[l*8 +: 8]);
    end
    if (room < 4) m_txovf = 1;
    do_bus(1, 1, 12'h0A0, d);
  endtask

  task automatic t_byte_push(input logic [7:0] b);
    if (txq.size() == DEPTH) m_txovf = 1;
    else txq.push_back(b);
    do_bus(1, 0, 12'h000, {24'h0, b});
  endtask

  task automatic t_word_pop(input string tag);
    logic [31:0] e;
    e = '0;
    for (int l = 0; l < 4; l++) begin
      if (rxq.size() > 0) e[l*8 +: 8] = rxq.pop_front();
    end
    do_bus(0, 1, 12'h0A4, '0);
    check(tag, bus_rdata, e);
  endtask

  task automatic t_byte_pop(input string tag);
    logic [31:0] e;
    e = '0;
    if (rxq.size() > 0) e[7:0] = rxq.pop_front();
    do_bus(0, 0, 12'h000, '0);
    check(tag, bus_rdata, e);
  endtask

  task automatic t_fctl(input logic [7:0] v);
    if (v == 8'h43) begin m_ovr = 0; m_txovf = 0; end
    do_bus(1, 0, 12'h002, {24'h0, v});
  endtask

  task automatic t_rx(input logic [7:0] b, input bit pe, input bit fe);
    if (rxq.size() == DEPTH) m_ovr = 1;
    else rxq.push_back(b);
    if (pe) m_pe = 1;
    if (fe) m_fe = 1;
    rx_in_valid = 1'b1; rx_in_byte = b; rx_in_perr = pe; rx_in_ferr = fe;
    @(posedge clk);
    @(negedge clk);
    rx_in_valid = 1'b0; rx_in_perr = 1'b0; rx_in_ferr = 1'b0;
  endtask

  task automatic t_drain(input string tag);
    tx_out_ready = 1'b1;
    while (txq.size() > 0) begin
      check({tag, " valid"}, {31'h0, tx_out_valid}, 32'h1);
      check({tag, " byte"}, {24'h0, tx_out_byte}, {24'h0, txq.pop_front()});
      @(negedge clk);
    end
    tx_out_ready = 1'b0;
    check({tag, " empty"}, {31'h0, tx_out_valid}, 32'h0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 rdata after reset", bus_rdata, 32'h0);
    check("R1 sink idle", {31'h0, tx_out_valid}, 32'h0);
    t_status(0, "R1 reset status");
    check("R1 reset status literal", bus_rdata, 32'h2010_1000);

    // R2 / R4 ordering through the sink
    t_word_push(32'h4433_2211);
    t_byte_push(8'h55);
    t_status(0, "R10 tx free after pushes");
    t_drain("R2 R4 tx order");

    // R3 partial word pop, R4 empty byte pop
    t_rx(8'hA1, 0, 0); t_rx(8'hA2, 0, 0); t_rx(8'hA3, 0, 0);
    t_word_pop("R3 partial word pop");
    check("R3 partial literal", bus_rdata, 32'h00A3_A2A1);
    t_byte_pop("R4 byte pop empty");
    t_status(0, "R3 rx empty after pop");

    // R9 read data holds across writes and idle
    t_rx(8'h7E, 0, 0);
    t_byte_pop("R4 byte pop");
    held = bus_rdata;
    t_byte_push(8'h01);
    @(negedge clk);
    check("R9 rdata held", bus_rdata, held);
    t_drain("R4 single byte");

    // R5 transmit overflow
    for (int i = 0; i < 4; i++) t_word_push(32'h1000_0000 * i + 32'h0302_0100);
    t_word_push(32'hDEAD_BEEF);
    t_byte_push(8'hEE);
    t_status(0, "R5 overflow set");
    t_fctl(8'h12);
    t_status(0, "R5 overflow held");
    t_fctl(8'h43);
    t_status(0, "R5 overflow cleared");
    t_drain("R5 kept bytes");
    t_word_push(32'h0A0B_0C0D); t_word_push(32'h1A1B_1C1D); t_word_push(32'h2A2B_2C2D);
    t_byte_push(8'h31); t_byte_push(8'h32);
    t_word_push(32'h4A4B_4C4D);
    t_status(0, "R5 partial word push");
    t_drain("R5 partial kept");
    t_fctl(8'h43);

    // R6 receive overrun
    for (int i = 0; i < DEPTH + 1; i++) t_rx(8'(8'h20 + i), 0, 0);
    t_status(0, "R6 overrun set");
    t_fctl(8'h00);
    t_status(0, "R6 overrun held");
    t_fctl(8'h43);
    t_status(0, "R6 overrun cleared");
    for (int i = 0; i < DEPTH / 4; i++) t_word_pop("R6 R3 drain rx");

    // R7 parity / framing
    t_rx(8'h11, 1, 0);
    t_rx(8'h12, 0, 1);
    t_status(0, "R7 flags reported");
    t_status(0, "R7 flags cleared by read");

    // R8 interrupt idle bit
    t_status(1, "R8 irq pending");
    t_status(0, "R8 irq idle");

    // R11 unmapped / wrong-width accesses
    do_bus(1, 1, 12'h09C, 32'hFFFF_FFFF);
    do_bus(1, 1, 12'h000, 32'h1234_5678);
    do_bus(0, 1, 12'h000, '0);
    check("R11 unmapped read zero", bus_rdata, 32'h0);
    do_bus(1, 0, 12'h0A0, 32'h0000_0099);
    t_status(0, "R11 no state change");
    t_word_pop("R11 rx unchanged");

    // Random phase
    for (int it = 0; it < 600; it++) begin
      int c;
      c = $urandom_range(0, 9);
      case (c)
        0, 1: t_rx(8'($urandom), ($urandom_range(0, 15) == 0), ($urandom_range(0, 15) == 0));
        2:    t_word_pop("R3 random word pop");
        3:    t_byte_pop("R4 random byte pop");
        4:    t_word_push($urandom);
        5:    t_byte_push(8'($urandom));
        6:    t_status(1'($urandom_range(0, 1)), "R10 random status");
        7:    t_fctl(($urandom_range(0, 1) == 0) ? 8'h43 : 8'($urandom));
        8:    if ($urandom_range(0, 3) == 0) t_drain("R2 random drain");
        default: t_rx(8'($urandom), 0, 0);
      endcase
    end
    t_drain("R2 final drain");
    t_status(0, "R10 final status");

    finish_run();
  end

endmodule